// File: doc/BRIEF.md
# External Interrupt Group Controller

This block watches 28 external interrupt pins. Each pin passes through a synchroniser and is then recognised as a level or an edge, according to a trigger-mode field that it shares with its neighbouring pin. A recognised event sets a sticky pending bit. A mask register decides which pending bits are forwarded. The forwarded bits are combined into four interrupt requests toward a vectored interrupt controller. These four groups are unequal: 4, 8, 8 and 8 lines.

Software uses a small word-addressed register bus with four registers: two trigger-configuration words, a mask word and a pending word. Reads are combinational from the registered state. Writes land on the next rising clock edge. An interrupt handler reads pending and mask, finds the lines that need service, and acknowledges them by writing ones into pending.

Top module: `ext_irq_group_ctrl`

## Requirements
- R1: After reset, both configuration words read 0, the mask word reads 0x0FFFFFFF (every line masked), the pending word reads 0 and all four group outputs are 0.
- R2: Register select 0 (byte offset 0x0) is configuration for lines 0–15, select 1 (0x4) is configuration for lines 16–27, select 2 (0x8) is mask and select 3 (0xC) is pending. Configuration reads return each stored 3-bit field with the fourth bit of every nibble as 0.
- R3: Mode code 000 sets pending on every cycle the synchronised pin is low, and code 001 does the same while it is high. A clear issued while the level is still active leaves the bit set.
- R4: Mode code 010 sets pending on a 1→0 transition, code 100 on a 0→1 transition and code 110 on either. After an edge, pending is set once, and a clear leaves it at 0 until the next qualifying edge.
- R5: Codes 011, 101 and 111 disable detection for the pair. Toggling such a pin never sets pending.
- R6: Lines 2k and 2k+1 share one 3-bit field at bit ((n mod 16)/2)*4 of the configuration word for line n: word 0 for n<16, word 1 otherwise.
- R7: Mask bit n = 1 blocks line n from its group output, while its pending bit still latches and reads back.
- R8: Writing 1 to pending bit n clears it. A 0 leaves it unchanged.
- R9: When a detection and a clear of the same bit land on the same clock edge, the bit ends up set.
- R10: Group output 0 is the OR of lines 0–3, output 1 of lines 4–11, output 2 of lines 12–19 and output 3 of lines 20–27, each taken as pending AND NOT mask.
- R11: A pin change becomes visible in pending at the third rising edge after it, and not at the second: two synchroniser stages, then the pending register.
- R12: Write data for bits that name no line is discarded. That means bits 28–31 of mask and pending, and bits 24–31 of configuration word 1. These bits read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 28 | Asynchronous external interrupt pins |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 2 | Word select (byte offset bits 3:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected word, combinational |
| irq_grp | output | 4 | Grouped interrupt requests |

## Verification
A corrupted pending or mask bit shows up at the ports in the same cycle in two places: the pending or mask read word, and the group output that covers that line. The bench therefore compares both after every step. A wrong synchroniser or previous-value register shifts the cycle in which pending rises, or produces a second set after a clear. Sampling one cycle before and exactly at the expected third edge exposes this within three clocks of the pin change. A misplaced or mis-decoded trigger field makes the wrong line respond, or none at all. This is caught because every mode code is swept over every line.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    localparam int NUM_LINES   = 28;
    localparam int DATA_W      = 32;
    localparam int MODE_W      = 3;
    localparam int NIB_W       = 4;
    localparam int NUM_PAIRS   = NUM_LINES / 2;
    localparam int PAIRS_WORD0 = DATA_W / NIB_W;
    localparam int PAIRS_WORD1 = NUM_PAIRS - PAIRS_WORD0;
    localparam int CFG_W       = NUM_PAIRS * MODE_W;
    localparam int NUM_GROUPS  = 4;
    localparam int GRP0_LINES  = 4;
    localparam int GRPN_LINES  = 8;

    localparam logic [MODE_W-1:0] MODE_LOW  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_HIGH = 3'b001;
    localparam logic [MODE_W-1:0] MODE_FALL = 3'b010;
    localparam logic [MODE_W-1:0] MODE_RISE = 3'b100;
    localparam logic [MODE_W-1:0] MODE_BOTH = 3'b110;

    typedef enum logic [1:0] {
        SEL_CFG_LO = 2'd0,
        SEL_CFG_HI = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_PEND   = 2'd3
    } reg_sel_e;

    function automatic int grp_first(input int g);
        return (g == 0) ? 0 : GRP0_LINES + (g - 1) * GRPN_LINES;
    endfunction

    function automatic int grp_last(input int g);
        return (g == 0) ? GRP0_LINES - 1 : grp_first(g) + GRPN_LINES - 1;
    endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W      = 28,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
    import eirq_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic [N-1:0]            cur,
    input  logic [N-1:0]            prev,
    input  logic [(N/2)*MODE_W-1:0] cfg,
    output logic [N-1:0]            hit
);

    for (genvar i = 0; i < N; i++) begin : g_line
        localparam int PAIR = i / 2;
        logic [MODE_W-1:0] mode;
        assign mode = cfg[PAIR*MODE_W +: MODE_W];

        always_comb begin
            case (mode)
                MODE_LOW:  hit[i] = ~cur[i];
                MODE_HIGH: hit[i] =  cur[i];
                MODE_FALL: hit[i] =  prev[i] & ~cur[i];
                MODE_RISE: hit[i] =  cur[i] & ~prev[i];
                MODE_BOTH: hit[i] =  cur[i] ^ prev[i];
                default:   hit[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/eirq_group.sv
module eirq_group
    import eirq_pkg::*;
(
    input  logic [NUM_LINES-1:0]  active,
    output logic [NUM_GROUPS-1:0] req
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int LO = grp_first(g);
        localparam int HI = grp_last(g);
        assign req[g] = |active[HI:LO];
    end

endmodule

// File: rtl/ext_irq_group_ctrl.sv
module ext_irq_group_ctrl
    import eirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LINES-1:0]  pin_in,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [1:0]            bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_GROUPS-1:0] irq_grp
);

    typedef struct packed {
        logic [CFG_W-1:0]     cfg;
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] prev;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LINES-1:0] sync_vec;
    logic [NUM_LINES-1:0] hit_vec;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] pend_vec;
    logic [NUM_LINES-1:0] mask_vec;
    reg_sel_e             sel;

    eirq_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_vec)
    );

    eirq_detect #(.N(NUM_LINES)) u_detect (
        .cur  (sync_vec),
        .prev (st_q.prev),
        .cfg  (st_q.cfg),
        .hit  (hit_vec)
    );

    assign sel = reg_sel_e'(bus_addr);

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        st_d.prev = sync_vec;
        if (bus_sel && bus_wr) begin
            case (sel)
                SEL_CFG_LO: begin
                    for (int p = 0; p < PAIRS_WORD0; p++)
                        st_d.cfg[p*MODE_W +: MODE_W] = bus_wdata[p*NIB_W +: MODE_W];
                end
                SEL_CFG_HI: begin
                    for (int p = 0; p < PAIRS_WORD1; p++)
                        st_d.cfg[(PAIRS_WORD0+p)*MODE_W +: MODE_W] = bus_wdata[p*NIB_W +: MODE_W];
                end
                SEL_MASK: st_d.mask = bus_wdata[NUM_LINES-1:0];
                SEL_PEND: clr_vec   = bus_wdata[NUM_LINES-1:0];
                default:  ;
            endcase
        end
        st_d.pend = (st_q.pend & ~clr_vec) | hit_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= '0;
            st_q.mask <= '1;
            st_q.pend <= '0;
            st_q.prev <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CFG_LO: begin
                for (int p = 0; p < PAIRS_WORD0; p++)
                    bus_rdata[p*NIB_W +: MODE_W] = st_q.cfg[p*MODE_W +: MODE_W];
            end
            SEL_CFG_HI: begin
                for (int p = 0; p < PAIRS_WORD1; p++)
                    bus_rdata[p*NIB_W +: MODE_W] = st_q.cfg[(PAIRS_WORD0+p)*MODE_W +: MODE_W];
            end
            SEL_MASK: bus_rdata[NUM_LINES-1:0] = st_q.mask;
            SEL_PEND: bus_rdata[NUM_LINES-1:0] = st_q.pend;
            default:  ;
        endcase
    end

    assign pend_vec = st_q.pend;
    assign mask_vec = st_q.mask;

    eirq_group u_group (
        .active (pend_vec & ~mask_vec),
        .req    (irq_grp)
    );

endmodule

// File: rtl/eirq_checker.sv
module eirq_checker
    import eirq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_sel,
    input logic                  bus_wr,
    input logic [1:0]            bus_addr,
    input logic [DATA_W-1:0]     bus_wdata,
    input logic [DATA_W-1:0]     bus_rdata,
    input logic [NUM_GROUPS-1:0] irq_grp,
    input logic [NUM_LINES-1:0]  pend,
    input logic [NUM_LINES-1:0]  mask
);

    logic [NUM_LINES-1:0] clr_req;
    assign clr_req = (bus_sel && bus_wr && bus_addr == 2'd3) ? bus_wdata[NUM_LINES-1:0] : '0;

    // R1: registers hold their reset values while reset is applied
    a_r1_reset_values: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && mask == '1));

    // R8: a pending bit only falls on an explicit write-one acknowledge
    a_r8_fall_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend) & ~pend) & ~$past(clr_req)) == '0));

    // R7: with every line masked no group request is raised
    a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> (irq_grp == '0));

    // R10: the four-line group follows its unmasked pending bits
    a_r10_group0_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grp[0] == |(pend[3:0] & ~mask[3:0]));

    // R12: bits naming no line read as zero
    a_r12_mask_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1]) |-> (bus_rdata[DATA_W-1:NUM_LINES] == '0));

    a_r12_cfg_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd1) |-> (bus_rdata[DATA_W-1:PAIRS_WORD1*NIB_W] == '0));

endmodule

bind ext_irq_group_ctrl eirq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_grp   (irq_grp),
    .pend      (pend_vec),
    .mask      (mask_vec)
);

// File: tb/tb_ext_irq_group_ctrl.sv
module tb_ext_irq_group_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ALL_LINES = 32'h0FFF_FFFF;
    localparam logic [31:0] CFG_OFF   = 32'h7777_7777;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] pins = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  irq;

    int n_vec = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_group_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pins),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq_grp   (irq)
    );

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic int grp_of(input int n);
        return (n < 4) ? 0 : (n - 4) / 8 + 1;
    endfunction

    function automatic logic [2:0] code_of(input int i);
        case (i)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b010;
            3: return 3'b100;
            4: return 3'b110;
            5: return 3'b011;
            6: return 3'b101;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [31:0] cfg_word(input int n, input logic [2:0] m);
        int sh;
        sh = ((n % 16) / 2) * 4;
        return (CFG_OFF & ~(32'hF << sh)) | ({29'd0, m} << sh);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [31:0] exp_p;

        // R1: reset state, observed while reset is held
        repeat (3) @(negedge clk);
        bus_read(2'd0, rv); check("R1", "cfg lo", rv, 32'h0);
        bus_read(2'd1, rv); check("R1", "cfg hi", rv, 32'h0);
        bus_read(2'd2, rv); check("R1", "mask", rv, ALL_LINES);
        bus_read(2'd3, rv); check("R1", "pending", rv, 32'h0);
        check("R1", "irq", {28'd0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R12: readback layout and discarded bits
        bus_write(2'd0, 32'hFFFF_FFFF);
        bus_read(2'd0, rv); check("R2", "cfg lo readback", rv, 32'h7777_7777);
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read(2'd1, rv); check("R12", "cfg hi readback", rv, 32'h0077_7777);
        bus_write(2'd2, 32'hFFFF_FFFF);
        bus_read(2'd2, rv); check("R12", "mask readback", rv, ALL_LINES);
        bus_write(2'd2, 32'hF000_0000);
        bus_read(2'd2, rv); check("R12", "mask upper write only", rv, 32'h0);
        bus_write(2'd0, 32'h1234_5670);
        bus_read(2'd0, rv); check("R2", "cfg lo pattern", rv, 32'h1234_5670);

        // Sweep every mode code over every line
        for (int n = 0; n < 28; n++) begin
            for (int mi = 0; mi < 8; mi++) begin
                logic [2:0] m;
                logic en, idle, lvl;
                m    = code_of(mi);
                en   = (mi < 5);
                idle = (m == 3'b000 || m == 3'b010);
                lvl  = (m == 3'b000 || m == 3'b001);
                pins = idle ? '1 : '0;
                bus_write(2'd0, CFG_OFF);
                bus_write(2'd1, CFG_OFF);
                repeat (3) @(negedge clk);
                bus_write(2'd3, ALL_LINES);
                bus_write(2'd2, 32'h0);
                bus_write((n < 16) ? 2'd0 : 2'd1, cfg_word(n, m));
                repeat (3) @(negedge clk);
                bus_read(2'd3, rv); check("R3", "idle level no set", rv, 32'h0);

                pins[n] = ~idle;
                repeat (2) @(negedge clk);
                bus_read(2'd3, rv); check("R11", "not yet at second edge", rv, 32'h0);
                @(negedge clk);
                exp_p = en ? (32'h1 << n) : 32'h0;
                bus_read(2'd3, rv);
                check(en ? "R6" : "R5", "pending after toggle", rv, exp_p);
                check("R10", "group output", {28'd0, irq}, en ? (32'h1 << grp_of(n)) : 32'h0);

                if (en) begin
                    bus_write(2'd3, ALL_LINES & ~(32'h1 << n));
                    bus_read(2'd3, rv); check("R8", "zero bit keeps pending", rv, exp_p);
                    bus_write(2'd2, 32'h1 << n);
                    check("R7", "masked irq", {28'd0, irq}, 32'h0);
                    bus_read(2'd3, rv); check("R7", "masked still pending", rv, exp_p);
                    bus_write(2'd2, 32'h0);
                    bus_write(2'd3, 32'h1 << n);
                    bus_read(2'd3, rv);
                    check(lvl ? "R3" : "R4", "clear while active", rv, lvl ? exp_p : 32'h0);
                    pins[n] = idle;
                    repeat (3) @(negedge clk);
                    bus_read(2'd3, rv);
                    check("R4", "after return to idle", rv, (m == 3'b110 || lvl) ? exp_p : 32'h0);
                    bus_write(2'd3, 32'h1 << n);
                    bus_read(2'd3, rv); check("R8", "final clear", rv, 32'h0);
                end else begin
                    pins[n] = idle;
                end
            end
        end

        // R9: edge set and acknowledge on the same edge
        pins = '0;
        bus_write(2'd0, CFG_OFF);
        bus_write(2'd1, CFG_OFF);
        repeat (3) @(negedge clk);
        bus_write(2'd3, ALL_LINES);
        bus_write(2'd0, cfg_word(5, 3'b100));
        repeat (3) @(negedge clk);
        pins[5] = 1'b1;
        @(negedge clk);
        bus_write(2'd3, 32'h1 << 5);
        bus_read(2'd3, rv); check("R9", "set wins over clear", rv, 32'h1 << 5);
        bus_write(2'd3, 32'h1 << 5);
        bus_read(2'd3, rv); check("R9", "later clear", rv, 32'h0);

        // R10: group mask sweep with every line pending
        bus_write(2'd0, 32'h1111_1111);
        bus_write(2'd1, 32'h1111_1111);
        pins = '1;
        repeat (3) @(negedge clk);
        bus_read(2'd3, rv); check("R3", "all high pending", rv, ALL_LINES);
        for (int gm = 0; gm < 16; gm++) begin
            logic [31:0] mw;
            mw = '0;
            if (gm[0]) mw |= 32'h0000_000F;
            if (gm[1]) mw |= 32'h0000_0FF0;
            if (gm[2]) mw |= 32'h000F_F000;
            if (gm[3]) mw |= 32'h0FF0_0000;
            bus_write(2'd2, mw);
            #1;
            check("R10", "group mask sweep", {28'd0, irq}, {28'd0, ~gm[3:0]});
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule